// File: doc/BRIEF.md
# Interleaved Wagging Handshake Shift Register

This block is a byte-wide shift register with handshake channels on both sides. Values arrive on a passive four-phase push input and leave on an active four-phase push output. The register always holds exactly 2K values. Every output transfer is paired with exactly one input transfer, so each value leaves the block 2K transfers after it entered.

Storage is split into K two-place sections. K is a parameter, 2 or 4. A round-robin pointer picks the section serving the current step. Each step runs in a fixed order: the older place of the selected section is offered on the output, the younger place is copied into the older one, and a new value is taken from the input into the younger place. The pointer then moves on to the next section and wraps modulo K. Each step only touches one short two-place chain, so it does not ripple through all 2K places.

A single controller state machine runs the step. The states are:
- START: leaves reset.
- EMIT: output request high.
- RELEASE: output request low, waiting for the acknowledge to drop.
- SHIFT: one-clock internal copy.
- ACCEPT: waiting for an input request.
- CLOSE: input acknowledge high, waiting for the request to drop.

The transitions are:
- START→EMIT: always, one cycle after reset.
- EMIT→RELEASE: on acknowledge high.
- RELEASE→SHIFT: on acknowledge low.
- SHIFT→ACCEPT: always.
- ACCEPT→CLOSE: on input request high. The data is captured on this edge.
- CLOSE→EMIT: on input request low. The pointer advances on this edge.

Top module: `wag_shift_reg`

## Requirements
- R1: While reset is low, out_req and in_ack are low. All storage clears to zero. The first output request after reset carries 0x00.
- R2: Output transfer number n carries the byte from input transfer n−2K. The first 2K outputs are 0x00. K=2 and K=4 are both supported.
- R3: Once out_req rises, it stays high and out_data stays unchanged until out_ack is seen high. Then out_req falls and does not rise again while out_ack is still high.
- R4: in_ack rises only after in_req has been seen high. It stays high while in_req stays high and falls once in_req is low. in_data is captured on the clock edge where in_req is first seen high; its value at any other time has no effect.
- R5: Within one step, the output handshake finishes before the input is accepted. in_ack is never high while out_req is high, and an in_req raised early is not acknowledged until the output handshake has returned to zero.
- R6: Sections are served in fixed cyclic order starting at section 0, and the pointer wraps modulo K. At the ports this shows as the exact 2K delay of R2 holding across many wraps of the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Input push request |
| in_ack | output | 1 | Input push acknowledge |
| in_data | input | 8 | Input byte, valid while in_req is high |
| out_req | output | 1 | Output push request |
| out_ack | input | 1 | Output push acknowledge |
| out_data | output | 8 | Output byte, valid while out_req is high |

## Verification
The hardest situation to reach from the ports is an impatient producer. The producer raises in_req, with data, while the block's own output request is still waiting for its acknowledge. The block must hold off the input acknowledge until the output handshake has fully returned to zero.

The stimulus gets there by randomly choosing, in each step, to present input data before answering the output request. It then holds the acknowledge back for several cycles and checks that in_ack stays low during that time. Random delays in every handshake phase, and input bytes that change while the request is low, cover the capture rule. Two instances, with K=2 and K=4, run in lockstep against reference delay lines.

// File: rtl/wag_pkg.sv
package wag_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_START   = 3'd0,
        ST_EMIT    = 3'd1,
        ST_RELEASE = 3'd2,
        ST_SHIFT   = 3'd3,
        ST_ACCEPT  = 3'd4,
        ST_CLOSE   = 3'd5
    } step_state_t;

endpackage

// File: rtl/wag_section.sv
// One two-place ripple section: a younger place fed from the input and
// an older place fed from the younger one.
module wag_section
    import wag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  move_en,
    input  logic  load_en,
    input  byte_t load_data,
    output byte_t older
);

    byte_t young_q;
    byte_t old_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            young_q <= '0;
            old_q   <= '0;
        end else begin
            if (move_en) begin
                old_q <= young_q;
            end
            if (load_en) begin
                young_q <= load_data;
            end
        end
    end

    assign older = old_q;

endmodule

// File: rtl/wag_ctrl.sv
// Step controller: emit, release, shift, accept, close; then advance the
// round-robin section pointer.
module wag_ctrl
    import wag_pkg::*;
#(
    parameter int unsigned SECTIONS = 4,
    localparam int unsigned PTR_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic             out_ack,
    output logic             in_ack,
    output logic             out_req,
    output logic             move_en,
    output logic             load_en,
    output logic [PTR_W-1:0] sel
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(SECTIONS - 1);

    step_state_t state_q, state_d;
    logic [PTR_W-1:0] sel_q, sel_d;

    // Next-state and pointer logic
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_START: begin
                state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ack) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!out_ack) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                state_d = ST_ACCEPT;
            end
            ST_ACCEPT: begin
                if (in_req) state_d = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (!in_req) begin
                    state_d = ST_EMIT;
                    sel_d   = (sel_q == LAST) ? '0 : sel_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_START;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        out_req = 1'b0;
        in_ack  = 1'b0;
        move_en = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            ST_EMIT:   out_req = 1'b1;
            ST_SHIFT:  move_en = 1'b1;
            ST_ACCEPT: load_en = in_req;
            ST_CLOSE:  in_ack  = 1'b1;
            default: ;
        endcase
    end

    assign sel = sel_q;

endmodule

// File: rtl/wag_out_mux.sv
// Selects the older place of the section named by the pointer.
module wag_out_mux
    import wag_pkg::*;
#(
    parameter int unsigned SECTIONS = 4,
    localparam int unsigned PTR_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1
) (
    input  byte_t [SECTIONS-1:0] olders,
    input  logic  [PTR_W-1:0]    sel,
    output byte_t                dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < SECTIONS; i++) begin
            if (sel == PTR_W'(i)) dout = olders[i];
        end
    end

endmodule

// File: rtl/wag_shift_reg.sv
module wag_shift_reg
    import wag_pkg::*;
#(
    parameter int unsigned SECTIONS = 4,
    localparam int unsigned PTR_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_req,
    output logic       in_ack,
    input  logic [7:0] in_data,
    output logic       out_req,
    input  logic       out_ack,
    output logic [7:0] out_data
);

    logic              move_en;
    logic              load_en;
    logic [PTR_W-1:0]  sel;
    byte_t [SECTIONS-1:0] olders;

    wag_ctrl #(.SECTIONS(SECTIONS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .out_ack (out_ack),
        .in_ack  (in_ack),
        .out_req (out_req),
        .move_en (move_en),
        .load_en (load_en),
        .sel     (sel)
    );

    for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
        wag_section u_sec (
            .clk       (clk),
            .rst_n     (rst_n),
            .move_en   (move_en && (sel == PTR_W'(g))),
            .load_en   (load_en && (sel == PTR_W'(g))),
            .load_data (in_data),
            .older     (olders[g])
        );
    end

    wag_out_mux #(.SECTIONS(SECTIONS)) u_mux (
        .olders (olders),
        .sel    (sel),
        .dout   (out_data)
    );

endmodule

// File: rtl/wag_shift_reg_chk.sv
module wag_shift_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_req,
    input logic       in_ack,
    input logic       out_req,
    input logic       out_ack,
    input logic [7:0] out_data
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_req && !in_ack));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> out_req);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> $stable(out_data));

    // R3
    no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_req && out_ack) |=> !out_req);

    // R4
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ack && !in_req) |=> !in_ack);

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && in_req) |=> in_ack);

    // R5
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_req && in_ack));

endmodule

bind wag_shift_reg wag_shift_reg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data)
);

// File: tb/tb_wag_shift_reg.sv
module tb_wag_shift_reg;

    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_req = 1'b0;
    logic       out_ack = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ack, in_ack2, out_req, out_req2;
    logic [7:0] out_data, out_data2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] ref4 [8];
    logic [7:0] ref2 [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    wag_shift_reg #(.SECTIONS(4)) dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
        .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
        .out_data(out_data)
    );

    wag_shift_reg #(.SECTIONS(2)) dut_k2 (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack2),
        .in_data(in_data), .out_req(out_req2), .out_ack(out_ack),
        .out_data(out_data2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] next_byte(input int step);
        if (step % 37 == 5)  return 8'hFF;
        if (step % 41 == 9)  return 8'h00;
        return 8'($urandom_range(0, 255));
    endfunction

    task automatic one_step(input int step);
        logic [7:0] exp4, exp2, held, val;
        bit early;
        int head4, head2;
        head4 = step % 8;
        head2 = step % 4;
        exp4  = ref4[head4];
        exp2  = ref2[head2];
        val   = next_byte(step);
        early = ($urandom_range(0, 3) == 0);
        // junk on in_data while request is low (R4: no effect)
        in_data = 8'($urandom_range(0, 255));
        if (early) begin
            in_data = val;
            in_req  = 1'b1;
        end
        while (!out_req) @(negedge clk);
        chk(out_req2 == out_req, "R6 lockstep out_req", out_req2, out_req);
        chk(out_data == exp4, "R2 K=4 output", out_data, exp4);
        chk(out_data2 == exp2, "R2 K=2 output", out_data2, exp2);
        held = out_data;
        idle($urandom_range(0, 3));
        if (early) begin
            idle(2);
            chk(in_ack == 1'b0, "R5 early in_req not acknowledged", in_ack, 0);
        end
        chk(out_req && out_data == held, "R3 request and data held", out_data, held);
        out_ack = 1'b1;
        while (out_req) @(negedge clk);
        idle($urandom_range(0, 3));
        chk(out_req == 1'b0, "R3 no new request while ack high", out_req, 0);
        out_ack = 1'b0;
        if (!early) begin
            idle($urandom_range(0, 3));
            in_data = val;
            in_req  = 1'b1;
        end
        while (!in_ack) @(negedge clk);
        chk(in_ack2 == 1'b1, "R6 lockstep in_ack", in_ack2, 1);
        chk(out_req == 1'b0, "R5 no output request during input ack", out_req, 0);
        idle($urandom_range(0, 2));
        chk(in_ack == 1'b1, "R4 ack held while req high", in_ack, 1);
        in_data = ~val;   // change after capture has no effect (R4)
        in_req  = 1'b0;
        while (in_ack) @(negedge clk);
        ref4[head4] = val;
        ref2[head2] = val;
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 8; i++) ref4[i] = 8'h00;
        for (int i = 0; i < 4; i++) ref2[i] = 8'h00;
        idle(4);
        // R1: quiet in reset
        chk(out_req == 1'b0 && in_ack == 1'b0, "R1 reset outputs low",
            {out_req, in_ack}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(out_req == 1'b1, "R1 first request after reset", out_req, 1);
        chk(out_data == 8'h00, "R1 first output zero", out_data, 0);
        for (int s = 0; s < STEPS; s++) one_step(s);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule